// File: doc/BRIEF.md
# Power-Managed Mode Controller

This block decides which clock domains of a small microcontroller receive a clock, and from which source. A single sleep strobe from the CPU puts the device either into full Sleep, where every clock and the primary oscillator are stopped, or into Idle, where only the CPU clock is gated and the peripherals keep running. The choice depends on an idle-enable control bit. A two-bit clock-select field names the source that the system runs from: primary, secondary or internal.

Only an interrupt, a watchdog time-out or a reset ends Sleep or Idle. A watchdog time-out while the CPU runs is turned into a reset request instead. After a wake from Idle the CPU is held off for a fixed ready delay and keeps the source it idled on. After a wake from Sleep the block either waits for the primary oscillator or, with fast start enabled, runs at once from the internal oscillator. Whenever the system runs from a fallback source after a wake, it moves to the primary source once that source reports ready. The primary-ready flag is synchronised inside the block. The oscillators, the glitch-free muxes and the watchdog counter sit outside and connect through the select and enable outputs.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is in Run: cpu_clk_en=1, per_clk_en=1, cpu_src=per_src=2'b00 (primary), pri_osc_run=1, wdt_rst_req=0, cpu_ready=0.
- R2: A sleep_req taken in Run with idle_en=0 (any clk_sel, including the reset value 2'b00) enters Sleep on the next cycle. In Sleep, cpu_clk_en=0, per_clk_en=0, pri_osc_run=0, osc_stat=0, and the primary-ready synchroniser is held clear.
- R3: A sleep_req taken in Run with idle_en=1 enters Idle on the next cycle: cpu_clk_en=0, per_clk_en=1, and per_src keeps the running source. idle_en without a sleep_req never changes either clock enable.
- R4: Sleep and Idle are left only on irq_wake or wdt_expire, or by reset. A sleep_req, a clk_sel change or a primary-ready change does not wake the block.
- R5: A wdt_expire in Run raises wdt_rst_req for exactly the next cycle and leaves the mode unchanged. A wdt_expire in Sleep or Idle wakes the block and raises no wdt_rst_req.
- R6: A wake from Sleep with fast_start_en=0 keeps both clock enables at 0 with pri_osc_run=1 until the synchronised primary-ready is seen. The next cycle is Run on primary (2'b00). With fast_start_en=1 the next cycle is Run on the internal source (2'b10).
- R7: A wake from Idle keeps cpu_clk_en=0 and per_clk_en=1 for READY_CYC cycles (10 by default: 1000 kHz internal clock times 10 us). Then Run begins, and cpu_ready is 1 for exactly the first Run cycle after any wake.
- R8: After a wake onto a non-primary source, the sources switch to primary (2'b00) one cycle after the synchronised primary-ready is 1. clk_sel changes are ignored while this switch is pending.
- R9: Source codes are 2'b00 primary, 2'b01 secondary and 2'b10 internal. clk_sel 2'b00 selects primary, 2'b01 selects secondary, and 2'b10 or 2'b11 selects internal. When no switch is pending, a change of clk_sel in Run, Idle or the ready delay is applied one cycle later. cpu_src and per_src always carry the same code.
- R10: osc_stat is 1 exactly when clocks run (Run, Idle or the ready delay), the source is primary and the synchronised primary-ready is 1.
- R11: pri_osc_ready passes through a two-flop synchroniser. A rise seen in the Sleep-wake wait gives cpu_ready three cycles after the input rises.
- R12: A sleep_req in Run in the same cycle as irq_wake or wdt_expire is not taken: the block stays in Run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset (also a wake source) |
| sleep_req | input | 1 | One-cycle sleep strobe from the CPU |
| idle_en | input | 1 | 1: the sleep strobe gives Idle; 0: it gives Sleep |
| clk_sel | input | 2 | Requested system clock source |
| irq_wake | input | 1 | Interrupt wake event |
| wdt_expire | input | 1 | Watchdog time-out pulse |
| pri_osc_ready | input | 1 | Primary oscillator ready, asynchronous |
| fast_start_en | input | 1 | Run from the internal oscillator while the primary starts after Sleep |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| cpu_src | output | 2 | CPU clock source code |
| per_src | output | 2 | Peripheral clock source code |
| pri_osc_run | output | 1 | Primary oscillator run enable |
| osc_stat | output | 1 | Primary oscillator supplies the system clock |
| wdt_rst_req | output | 1 | Device reset request from a watchdog time-out in Run |
| cpu_ready | output | 1 | One-cycle strobe: the CPU resumes after a wake |

## Verification
The hardest situation to reach is a pending switch to primary that is still open when the CPU resumes. It needs a wake onto a fallback source while the primary oscillator is not ready, and in Idle the primary usually keeps running and is already ready. The stimulus gets there with a fast-start wake from Sleep. The bench's oscillator model then holds primary-ready low for a random 2 to 12 cycles after pri_osc_run returns, and a clk_sel write lands inside that window. Long random runs mix strobes, wake events and control-bit flips against a cycle model in the bench, so that wakes, watchdog pulses and sleep strobes also coincide with the delay and wait states.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    M_RUN     = 3'd0,
    M_IDLE    = 3'd1,
    M_SLEEP   = 3'd2,
    M_SLPWAIT = 3'd3,
    M_WAKEDLY = 3'd4
  } pmc_mode_e;

  typedef enum logic [1:0] {
    SRC_PRI = 2'd0,
    SRC_SEC = 2'd1,
    SRC_INT = 2'd2
  } pmc_src_e;

  // Map the software clock-select field to a source code.
  function automatic pmc_src_e sel_to_src(input logic [1:0] sel);
    if (sel[1])      return SRC_INT;
    else if (sel[0]) return SRC_SEC;
    else             return SRC_PRI;
  endfunction

  // Ready delay in cycles of the controller clock, at least one.
  function automatic int unsigned ready_cycles(input int unsigned osc_khz,
                                               input int unsigned delay_us);
    int unsigned c;
    c = (osc_khz * delay_us) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/pmc_sync2.sv
module pmc_sync2 #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   chain <= '0;
    else if (clr) chain <= '0;
    else          chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

  // R11
  sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q) |-> $past(d, STAGES));

  // R2
  sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !q);

endmodule

// File: rtl/pmc_ready_timer.sv
module pmc_ready_timer #(
  parameter int unsigned CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run)         cnt <= '0;
    else if (cnt != LAST)  cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);

  // R7
  tmr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$past(run)) |-> (cnt == '0));

endmodule

// File: rtl/pmc_src_track.sv
module pmc_src_track
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] clk_sel,
  input  logic       pri_rdy_s,
  input  logic       track_en,
  input  logic       ev_sleep,
  input  logic       ev_wake_fast,
  input  logic       ev_slp_done,
  input  logic       ev_wake_idle,
  output pmc_src_e   sys_src,
  output logic       pend
);
  logic [1:0] sel_q;
  logic       sel_changed;
  logic       pend_hit;

  assign sel_changed = (clk_sel != sel_q);
  assign pend_hit    = pend && pri_rdy_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_src <= SRC_PRI;
      pend    <= 1'b0;
      sel_q   <= 2'b00;
    end else begin
      sel_q <= clk_sel;
      if (ev_sleep) begin
        pend <= 1'b0;
      end else if (ev_wake_fast) begin
        sys_src <= SRC_INT;
        pend    <= 1'b1;
      end else if (ev_slp_done) begin
        sys_src <= SRC_PRI;
        pend    <= 1'b0;
      end else if (track_en) begin
        if (pend) begin
          if (pend_hit) begin
            sys_src <= SRC_PRI;
            pend    <= 1'b0;
          end
        end else if (ev_wake_idle && (sys_src != SRC_PRI)) begin
          pend <= 1'b1;
        end else if (sel_changed) begin
          sys_src <= sel_to_src(clk_sel);
        end
      end
    end
  end

  // R8
  pend_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (track_en && pend && pri_rdy_s && !ev_sleep) |=> (sys_src == SRC_PRI && !pend));

  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (track_en && pend && !pri_rdy_s && !ev_sleep) |=> $stable(sys_src));

  // R9
  sel_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (track_en && !pend && !ev_sleep && !ev_wake_idle && clk_sel[1] && (clk_sel != sel_q))
      |=> (sys_src == SRC_INT));

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_req,
  input  logic      idle_en,
  input  logic      irq_wake,
  input  logic      wdt_expire,
  input  logic      fast_start_en,
  input  logic      pri_rdy_s,
  input  logic      tmr_done,
  output pmc_mode_e mode,
  output logic      cpu_ready,
  output logic      wdt_rst_req,
  output logic      ev_sleep,
  output logic      ev_wake_fast,
  output logic      ev_slp_done,
  output logic      ev_wake_idle
);
  pmc_mode_e mode_nx;
  logic      rdy_nx;
  logic      wake;
  logic      sleep_take;

  assign wake       = irq_wake | wdt_expire;
  assign sleep_take = (mode == M_RUN) && sleep_req && !wake;

  assign ev_sleep     = sleep_take && !idle_en;
  assign ev_wake_fast = (mode == M_SLEEP) && wake && fast_start_en;
  assign ev_slp_done  = (mode == M_SLPWAIT) && pri_rdy_s;
  assign ev_wake_idle = (mode == M_IDLE) && wake;

  always_comb begin
    mode_nx = mode;
    rdy_nx  = 1'b0;
    unique case (mode)
      M_RUN:     if (sleep_take) mode_nx = idle_en ? M_IDLE : M_SLEEP;
      M_IDLE:    if (wake) mode_nx = M_WAKEDLY;
      M_WAKEDLY: if (tmr_done) begin
                   mode_nx = M_RUN;
                   rdy_nx  = 1'b1;
                 end
      M_SLEEP:   if (wake) begin
                   if (fast_start_en) begin
                     mode_nx = M_RUN;
                     rdy_nx  = 1'b1;
                   end else begin
                     mode_nx = M_SLPWAIT;
                   end
                 end
      M_SLPWAIT: if (pri_rdy_s) begin
                   mode_nx = M_RUN;
                   rdy_nx  = 1'b1;
                 end
      default:   mode_nx = M_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode        <= M_RUN;
      cpu_ready   <= 1'b0;
      wdt_rst_req <= 1'b0;
    end else begin
      mode        <= mode_nx;
      cpu_ready   <= rdy_nx;
      wdt_rst_req <= (mode == M_RUN) && wdt_expire;
    end
  end

  // R2
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RUN && sleep_req && !idle_en && !irq_wake && !wdt_expire) |=> (mode == M_SLEEP));

  // R3
  idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RUN && sleep_req && idle_en && !irq_wake && !wdt_expire) |=> (mode == M_IDLE));

  // R4
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SLEEP && !irq_wake && !wdt_expire) |=> (mode == M_SLEEP));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_IDLE && !irq_wake && !wdt_expire) |=> (mode == M_IDLE));

  // R5
  wdt_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RUN && wdt_expire) |=> (mode == M_RUN && wdt_rst_req));

  // R5
  wdt_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_IDLE && wdt_expire) |=> (mode == M_WAKEDLY && !wdt_rst_req));

  // R7
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  // R7
  ready_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> (mode == M_RUN && $past(mode) != M_RUN));

  // R12
  wake_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RUN && sleep_req && irq_wake) |=> (mode == M_RUN));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned INTOSC_KHZ  = 1000,
  parameter int unsigned READY_US    = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       idle_en,
  input  logic [1:0] clk_sel,
  input  logic       irq_wake,
  input  logic       wdt_expire,
  input  logic       pri_osc_ready,
  input  logic       fast_start_en,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic [1:0] cpu_src,
  output logic [1:0] per_src,
  output logic       pri_osc_run,
  output logic       osc_stat,
  output logic       wdt_rst_req,
  output logic       cpu_ready
);
  localparam int unsigned READY_CYC = ready_cycles(INTOSC_KHZ, READY_US);

  pmc_mode_e mode;
  pmc_src_e  sys_src;
  logic      pri_rdy_s;
  logic      tmr_done;
  logic      track_en;
  logic      sync_clr;
  logic      pend;
  logic      ev_sleep, ev_wake_fast, ev_slp_done, ev_wake_idle;

  assign track_en = (mode == M_RUN) || (mode == M_IDLE) || (mode == M_WAKEDLY);
  assign sync_clr = (mode == M_SLEEP);

  pmc_sync2 #(.STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (sync_clr),
    .d     (pri_osc_ready),
    .q     (pri_rdy_s)
  );

  pmc_ready_timer #(.CYCLES(READY_CYC)) u_ready_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (mode == M_WAKEDLY),
    .done  (tmr_done)
  );

  pmc_mode_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep_req     (sleep_req),
    .idle_en       (idle_en),
    .irq_wake      (irq_wake),
    .wdt_expire    (wdt_expire),
    .fast_start_en (fast_start_en),
    .pri_rdy_s     (pri_rdy_s),
    .tmr_done      (tmr_done),
    .mode          (mode),
    .cpu_ready     (cpu_ready),
    .wdt_rst_req   (wdt_rst_req),
    .ev_sleep      (ev_sleep),
    .ev_wake_fast  (ev_wake_fast),
    .ev_slp_done   (ev_slp_done),
    .ev_wake_idle  (ev_wake_idle)
  );

  pmc_src_track u_src (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_sel      (clk_sel),
    .pri_rdy_s    (pri_rdy_s),
    .track_en     (track_en),
    .ev_sleep     (ev_sleep),
    .ev_wake_fast (ev_wake_fast),
    .ev_slp_done  (ev_slp_done),
    .ev_wake_idle (ev_wake_idle),
    .sys_src      (sys_src),
    .pend         (pend)
  );

  assign cpu_clk_en  = (mode == M_RUN);
  assign per_clk_en  = track_en;
  assign cpu_src     = sys_src;
  assign per_src     = sys_src;
  assign pri_osc_run = (mode != M_SLEEP);
  assign osc_stat    = track_en && (sys_src == SRC_PRI) && pri_rdy_s;

  // R6
  slp_wait_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SLEEP && irq_wake && !fast_start_en) |=> (!per_clk_en && pri_osc_run));

  // R6
  fast_wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SLEEP && irq_wake && fast_start_en) |=> (cpu_clk_en && cpu_src == 2'b10 && pend));

  // R10
  stat_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pri_osc_run) |-> !osc_stat);

endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  function automatic int bench_ready(input int khz, input int us);
    int v;
    v = khz * us / 1000;
    if (v < 1) v = 1;
    return v;
  endfunction

  function automatic logic [1:0] bench_src(input logic [1:0] sel);
    case (sel)
      2'b00:   return 2'b00;
      2'b01:   return 2'b01;
      default: return 2'b10;
    endcase
  endfunction

  localparam int READY_CYC = bench_ready(1000, 10);
  localparam int S_RUN = 0, S_IDLE = 1, S_SLEEP = 2, S_WAIT = 3, S_DLY = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_req = 0, idle_en = 0, irq_wake = 0, wdt_expire = 0, fast_start_en = 0;
  logic [1:0] clk_sel = 2'b00;
  logic osc_async = 1'b0;
  logic cpu_clk_en, per_clk_en, pri_osc_run, osc_stat, wdt_rst_req, cpu_ready;
  logic [1:0] cpu_src, per_src;

  int n_chk = 0, n_fail = 0;
  bit chk_on = 0, finished = 0;
  int osc_wait = 5;

  // bench cycle model
  int m_st = S_RUN, m_cnt = 0;
  logic [1:0] m_src = 0, m_selq = 0;
  logic m_pend = 0, m_s1 = 0, m_s2 = 0, m_rdy = 0, m_wreq = 0;

  pwr_mode_ctrl u_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .idle_en(idle_en),
    .clk_sel(clk_sel), .irq_wake(irq_wake), .wdt_expire(wdt_expire),
    .pri_osc_ready(osc_async), .fast_start_en(fast_start_en),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .cpu_src(cpu_src),
    .per_src(per_src), .pri_osc_run(pri_osc_run), .osc_stat(osc_stat),
    .wdt_rst_req(wdt_rst_req), .cpu_ready(cpu_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  function automatic bit m_live(input int s);
    return (s == S_RUN) || (s == S_IDLE) || (s == S_DLY);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = S_RUN; m_cnt = 0; m_src = 0; m_selq = 0;
      m_pend = 0; m_s1 = 0; m_s2 = 0; m_rdy = 0; m_wreq = 0;
    end else begin
      automatic bit wk = irq_wake | wdt_expire;
      automatic int o_st = m_st;
      automatic logic o_s2 = m_s2;
      automatic logic [1:0] o_src = m_src;
      automatic logic o_pend = m_pend;
      automatic logic [1:0] o_selq = m_selq;
      if (o_st == S_SLEEP) begin m_s1 = 0; m_s2 = 0; end
      else begin m_s2 = m_s1; m_s1 = osc_async; end
      m_wreq = (o_st == S_RUN) && wdt_expire;
      m_rdy = 0;
      case (o_st)
        S_RUN:   if (!wk && sleep_req) m_st = idle_en ? S_IDLE : S_SLEEP;
        S_IDLE:  if (wk) begin m_st = S_DLY; m_cnt = 0; end
        S_DLY:   if (m_cnt == READY_CYC - 1) begin m_st = S_RUN; m_rdy = 1; end
                 else m_cnt++;
        S_SLEEP: if (wk) begin
                   if (fast_start_en) begin m_st = S_RUN; m_rdy = 1; end
                   else m_st = S_WAIT;
                 end
        default: if (o_s2) begin m_st = S_RUN; m_rdy = 1; end
      endcase
      m_selq = clk_sel;
      if (o_st == S_RUN && !wk && sleep_req && !idle_en) m_pend = 0;
      else if (o_st == S_SLEEP && wk && fast_start_en) begin m_src = 2'b10; m_pend = 1; end
      else if (o_st == S_WAIT && o_s2) begin m_src = 2'b00; m_pend = 0; end
      else if (m_live(o_st)) begin
        if (o_pend) begin
          if (o_s2) begin m_src = 2'b00; m_pend = 0; end
        end else if (o_st == S_IDLE && wk && o_src != 2'b00) m_pend = 1;
        else if (clk_sel != o_selq) m_src = bench_src(clk_sel);
      end
    end
  end

  // per-cycle comparison and primary oscillator model
  always @(negedge clk) begin
    if (chk_on) begin
      chk("R2 cpu_clk_en", cpu_clk_en, m_st == S_RUN);
      chk("R3 per_clk_en", per_clk_en, m_live(m_st));
      chk("R9 cpu_src", cpu_src, m_src);
      chk("R9 per_src", per_src, m_src);
      chk("R2 pri_osc_run", pri_osc_run, m_st != S_SLEEP);
      chk("R10 osc_stat", osc_stat, m_live(m_st) && m_src == 2'b00 && m_s2);
      chk("R7 cpu_ready", cpu_ready, m_rdy);
      chk("R5 wdt_rst_req", wdt_rst_req, m_wreq);
    end
    if (m_st == S_SLEEP) begin
      osc_async = 0;
      osc_wait = $urandom_range(2, 12);
    end else if (osc_wait > 0) osc_wait--;
    else osc_async = 1;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int rise_at;
    bit seen;
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk_on = 1;
    // R1 reset state
    chk("R1 cpu_clk_en", cpu_clk_en, 1);
    chk("R1 per_clk_en", per_clk_en, 1);
    chk("R1 cpu_src", cpu_src, 0);
    chk("R1 pri_osc_run", pri_osc_run, 1);
    chk("R1 wdt_rst_req", wdt_rst_req, 0);
    chk("R1 cpu_ready", cpu_ready, 0);
    repeat (20) tick();
    chk("R10 osc_stat on primary", osc_stat, 1);

    // R12 wake beats sleep strobe
    sleep_req = 1; irq_wake = 1; tick(); sleep_req = 0; irq_wake = 0;
    chk("R12 stays in run", cpu_clk_en, 1);

    // R2 full sleep
    sleep_req = 1; tick(); sleep_req = 0;
    chk("R2 cpu gated", cpu_clk_en, 0);
    chk("R2 per gated", per_clk_en, 0);
    chk("R2 primary stopped", pri_osc_run, 0);
    chk("R2 osc_stat clear", osc_stat, 0);
    // R4 no wake from strobe or select change
    sleep_req = 1; clk_sel = 2'b01; tick(); sleep_req = 0; tick();
    clk_sel = 2'b00; tick();
    chk("R4 still asleep", per_clk_en, 0);
    chk("R4 cpu still off", cpu_clk_en, 0);

    // R6 / R11 wake from sleep, no fast start
    irq_wake = 1; tick(); irq_wake = 0;
    chk("R6 wait dark", per_clk_en, 0);
    chk("R6 primary running", pri_osc_run, 1);
    rise_at = -1; seen = 0;
    for (int i = 0; i < 30 && !seen; i++) begin
      tick();
      if (osc_async && rise_at < 0) rise_at = i;
      if (cpu_ready) begin
        seen = 1;
        chk("R6 run on primary", cpu_src, 0);
        chk("R11 sync latency", i - rise_at, 3);
      end else chk("R6 cpu held", cpu_clk_en, 0);
    end
    chk("R6 cpu_ready seen", seen, 1);

    // R5 watchdog in run
    wdt_expire = 1; tick(); wdt_expire = 0;
    chk("R5 reset request", wdt_rst_req, 1);
    chk("R5 still run", cpu_clk_en, 1);
    tick();
    chk("R5 single pulse", wdt_rst_req, 0);

    // R9 select internal, R3 idle
    clk_sel = 2'b11; tick();
    chk("R9 internal code", cpu_src, 2);
    idle_en = 1; tick();
    chk("R3 idle_en alone", cpu_clk_en, 1);
    sleep_req = 1; tick(); sleep_req = 0;
    chk("R3 cpu off in idle", cpu_clk_en, 0);
    chk("R3 per on in idle", per_clk_en, 1);
    chk("R3 per source kept", per_src, 2);

    // R7 / R8 watchdog wake from idle
    wdt_expire = 1; tick(); wdt_expire = 0;
    chk("R5 no reset in idle", wdt_rst_req, 0);
    chk("R8 idle source kept", cpu_src, 2);
    for (int k = 1; k <= READY_CYC; k++) begin
      tick();
      if (k == 1) chk("R8 switch to primary", cpu_src, 0);
      if (k < READY_CYC) chk("R7 delay holds cpu", cpu_clk_en, 0);
      else begin
        chk("R7 cpu_ready after delay", cpu_ready, 1);
        chk("R7 cpu running", cpu_clk_en, 1);
      end
    end
    tick();
    chk("R7 ready one cycle", cpu_ready, 0);

    // R6 / R8 fast-start wake from sleep
    idle_en = 0; clk_sel = 2'b00; fast_start_en = 1; tick();
    sleep_req = 1; tick(); sleep_req = 0;
    chk("R2 asleep again", pri_osc_run, 0);
    tick();
    irq_wake = 1; tick(); irq_wake = 0;
    chk("R6 fast wake runs", cpu_clk_en, 1);
    chk("R6 fast wake ready", cpu_ready, 1);
    chk("R6 internal source", cpu_src, 2);
    clk_sel = 2'b01; tick();
    chk("R8 select ignored while pending", cpu_src, 2);
    seen = 0;
    for (int i = 0; i < 30 && !seen; i++) begin
      tick();
      if (cpu_src == 2'b00) seen = 1;
    end
    chk("R8 pending switch done", seen, 1);
    tick();
    chk("R10 osc_stat after switch", osc_stat, 1);
    clk_sel = 2'b00; fast_start_en = 0; tick();

    // random phase against the cycle model
    for (int i = 0; i < 6000; i++) begin
      sleep_req  = ($urandom_range(0, 7) == 0);
      irq_wake   = ($urandom_range(0, 19) == 0);
      wdt_expire = ($urandom_range(0, 39) == 0);
      if ($urandom_range(0, 15) == 0) idle_en = ~idle_en;
      if ($urandom_range(0, 31) == 0) clk_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 31) == 0) fast_start_en = ~fast_start_en;
      tick();
    end
    sleep_req = 0; irq_wake = 0; wdt_expire = 0;
    tick();

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule